// File: doc/BRIEF.md
# In-Band Interrupt Chunk Ring Receiver

This block takes in-band interrupt payloads from a byte-wide receive interface and stores them in two internal memories. The payload bytes go into a circular pool of equal, power-of-two sized data chunks. Descriptors for each payload go into a circular status ring. A payload that is short enough is described by one status entry. A longer payload is described by a chain of entries. Every entry except the last reports a fixed number of completely filled chunks. The closing entry is marked as the last one and reports the exact byte count of its own segment.

Software reads entries and bytes through two combinational read ports. It reports how far it has consumed the status ring through a dequeue pointer. It hands chunks back by pulsing a credit count, which makes those chunks free again. The block raises a one-cycle ready interrupt each time an event has been closed. It raises a one-cycle ring-full interrupt when it runs out of chunks or status slots. When that happens, the rest of the payload is discarded and the closing entry carries an error flag.

Top module: `ibi_chunk_ring`

## Requirements
- R1: Chunks are 2^(CHUNK_CODE+2) bytes. Every event starts on a fresh chunk, and byte i of an event is stored at offset i mod chunk size inside the chunk in use. The data read port addresses a byte as chunk index times chunk size plus offset.
- R2: A status entry is 32 bits: bit 31 last flag, bit 30 error flag, bits [29:23] target address, bits [19:12] chunk count, bits [11:0] byte length, all other bits zero.
- R3: An event of at most SEG_CHUNKS*chunk-size bytes produces a single entry with the last flag set, its length in bytes, and a chunk count of length divided by chunk size, rounded up.
- R4: In a longer event, each time SEG_CHUNKS chunks are filled and more bytes follow, a non-final entry is written with chunk count SEG_CHUNKS, length 0 and last flag clear. The closing entry reports the bytes of the final segment. All entries of the event carry the address given with its first byte.
- R5: The status enqueue pointer advances by one for each entry written and wraps from STAT_DEPTH-1 to 0. An entry is never written into the slot that would make the enqueue pointer equal to the software dequeue pointer.
- R6: Chunks are allocated in circular order. After chunk NUM_CHUNKS-1 comes chunk 0.
- R7: After reset all NUM_CHUNKS chunks are free. Each allocation uses one chunk. A credit pulse frees credit_count chunks, and the free count saturates at NUM_CHUNKS.
- R8: If a byte needs a new chunk and none is free, that byte and the rest of the event are discarded. The memory keeps its contents. The closing entry has the error flag set and reports the chunks and bytes actually stored in its segment, and irq_ring_full pulses once.
- R9: If a non-final entry is due but fewer than two status slots are free, no entry is written. The rest of the event is discarded, the closing entry reports the error, and irq_ring_full pulses once.
- R10: An event whose first byte arrives while no status slot is free writes no entry and stores no data. It leaves the enqueue pointer unchanged, pulses irq_ring_full, and does not pulse irq_ibi_ready.
- R11: irq_ibi_ready pulses for exactly one cycle in the cycle after the clock edge that wrote an entry with the last flag set. It never pulses for a non-final entry.
- R12: After reset the enqueue pointer is 0 and both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_valid | input | 1 | A payload byte is present this cycle |
| rx_addr | input | 7 | Target address, taken from the first byte of an event |
| rx_data | input | 8 | Payload byte |
| rx_last | input | 1 | This byte ends the event |
| credit_valid | input | 1 | Software returns chunks this cycle |
| credit_count | input | 10 | Number of chunks returned |
| stat_deq | input | 8 | Software status dequeue pointer |
| stat_enq | output | 8 | Status enqueue pointer |
| stat_rd_idx | input | 8 | Status entry read index |
| stat_rd_entry | output | 32 | Status entry at the read index |
| data_rd_addr | input | DATA_AW | Byte address in the chunk pool |
| data_rd_byte | output | 8 | Byte at the data read address |
| irq_ibi_ready | output | 1 | One-cycle pulse after a closing entry is written |
| irq_ring_full | output | 1 | One-cycle pulse when chunks or status slots run out |

## Verification
Some rules are checked by the assertions on every cycle. No entry is written without a free slot, and no chunk is allocated while none is free. The enqueue pointer only holds or steps by one with wrap. Every non-final entry has the fixed chunk count and zero length. The ready pulse follows exactly the writes of closing entries.

Other behaviour only the bench scenarios can show. This covers byte placement across chunk boundaries and the chunk wrap, and the arithmetic split of lengths into segments. It also covers the reported counts on an error entry, that credits really make chunks usable again, and that discarded bytes leave the memory untouched.

// File: rtl/ibi_ring_pkg.sv
package ibi_ring_pkg;

  localparam int TADDR_W = 7;
  localparam int CNT_FW  = 8;
  localparam int LEN_FW  = 12;

  // status entry layout: [31] last, [30] error, [29:23] address,
  // [22:20] zero, [19:12] chunk count, [11:0] byte length
  typedef struct packed {
    logic               fin;
    logic               err;
    logic [TADDR_W-1:0] addr;
    logic [2:0]         rsvd;
    logic [CNT_FW-1:0]  chunks;
    logic [LEN_FW-1:0]  len;
  } ibi_stat_t;

endpackage

// File: rtl/ibi_stat_ring.sv
module ibi_stat_ring #(
  parameter int DEPTH = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [31:0]      push_entry,
  input  logic [7:0]       deq_ptr,
  input  logic [7:0]       rd_idx,
  output logic [7:0]       enq_ptr,
  output logic [31:0]      rd_entry,
  output logic [IDX_W-1:0] slots_free
);

  logic [31:0]      mem [0:DEPTH-1];
  logic [IDX_W-1:0] enq_q, enq_d;
  logic [8:0]       enq_x, deq_x, used;

  always_comb begin
    enq_x = 9'(enq_q);
    deq_x = {1'b0, deq_ptr};
    if (enq_x >= deq_x) used = enq_x - deq_x;
    else                used = enq_x + 9'(DEPTH) - deq_x;
    slots_free = IDX_W'(9'(DEPTH - 1) - used);
  end

  always_comb begin
    enq_d = enq_q;
    if (push) begin
      if (enq_q == IDX_W'(DEPTH - 1)) enq_d = '0;
      else                            enq_d = enq_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     enq_q <= '0;
    else if (push)  enq_q <= enq_d;
  end

  always_ff @(posedge clk) begin
    if (push) mem[enq_q] <= push_entry;
  end

  assign enq_ptr  = 8'(enq_q);
  assign rd_entry = (rd_idx < 8'(DEPTH)) ? mem[rd_idx[IDX_W-1:0]] : 32'd0;

endmodule

// File: rtl/ibi_chunk_pool.sv
module ibi_chunk_pool #(
  parameter int NUM_CHUNKS  = 8,
  parameter int CHUNK_BYTES = 4,
  parameter int CHK_W       = 3,
  parameter int OFF_W       = 2,
  parameter int CNT_W       = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc,
  input  logic                   store,
  input  logic [OFF_W-1:0]       wr_off,
  input  logic [7:0]             wr_data,
  input  logic                   credit_valid,
  input  logic [9:0]             credit_count,
  input  logic [CHK_W+OFF_W-1:0] rd_addr,
  output logic [7:0]             rd_byte,
  output logic [CNT_W-1:0]       free_chunks
);

  localparam int BYTES = NUM_CHUNKS * CHUNK_BYTES;

  logic [7:0]             mem [0:BYTES-1];
  logic [CHK_W-1:0]       next_q, next_d, cur_q, wr_chunk;
  logic [CNT_W-1:0]       free_q, free_d;
  logic [11:0]            sum;
  logic [CHK_W+OFF_W-1:0] waddr;

  always_comb begin
    wr_chunk = alloc ? next_q : cur_q;
    waddr    = {wr_chunk, wr_off};
    if (next_q == CHK_W'(NUM_CHUNKS - 1)) next_d = '0;
    else                                  next_d = next_q + CHK_W'(1);
    sum = 12'(free_q) - 12'(alloc) + (credit_valid ? 12'(credit_count) : 12'd0);
    if (sum > 12'(NUM_CHUNKS)) free_d = CNT_W'(NUM_CHUNKS);
    else                       free_d = CNT_W'(sum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      next_q <= '0;
      cur_q  <= '0;
    end else if (alloc) begin
      next_q <= next_d;
      cur_q  <= next_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       free_q <= CNT_W'(NUM_CHUNKS);
    else if (alloc || credit_valid)   free_q <= free_d;
  end

  always_ff @(posedge clk) begin
    if (store) mem[waddr] <= wr_data;
  end

  assign rd_byte     = (32'(rd_addr) < BYTES) ? mem[rd_addr] : 8'd0;
  assign free_chunks = free_q;

endmodule

// File: rtl/ibi_rx_ctrl.sv
module ibi_rx_ctrl
  import ibi_ring_pkg::*;
#(
  parameter int CHUNK_BYTES = 4,
  parameter int OFF_W       = 2,
  parameter int SEG_CHUNKS  = 2,
  parameter int IDX_W       = 3,
  parameter int CNT_W       = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [TADDR_W-1:0] rx_addr,
  input  logic [7:0]         rx_data,
  input  logic               rx_last,
  input  logic [IDX_W-1:0]   slots_free,
  input  logic [CNT_W-1:0]   free_chunks,
  output logic               alloc,
  output logic               store,
  output logic [OFF_W-1:0]   wr_off,
  output logic [7:0]         wr_data,
  output logic               push,
  output ibi_stat_t          entry,
  output logic               irq_ready,
  output logic               irq_full
);

  logic               evt_q, evt_d, drop_q, drop_d, ovf_q, ovf_d;
  logic [TADDR_W-1:0] addr_q, addr_d, addr_u;
  logic [CNT_FW-1:0]  segc_q, segc_d, segc_u, segc_inc;
  logic [LEN_FW-1:0]  segb_q, segb_d, segb_u, segb_inc;
  logic [OFF_W-1:0]   off_q, off_d, off_u;
  logic               rdy_q, rdy_d, full_q, full_d;
  logic               first, drop_now, ovf_u, need_chunk, seg_done, two_slots;

  always_comb begin
    first      = !evt_q;
    drop_now   = first ? (slots_free == '0) : drop_q;
    ovf_u      = first ? 1'b0 : ovf_q;
    addr_u     = first ? rx_addr : addr_q;
    segc_u     = first ? '0 : segc_q;
    segb_u     = first ? '0 : segb_q;
    off_u      = first ? '0 : off_q;
    need_chunk = (off_u == '0);
    segc_inc   = segc_u + CNT_FW'(need_chunk);
    segb_inc   = segb_u + LEN_FW'(1);
    seg_done   = (off_u == OFF_W'(CHUNK_BYTES - 1)) && (segc_inc == CNT_FW'(SEG_CHUNKS));
    two_slots  = ({1'b0, slots_free} >= (IDX_W+1)'(2));

    evt_d  = evt_q;  drop_d = drop_q; ovf_d = ovf_q; addr_d = addr_q;
    segc_d = segc_q; segb_d = segb_q; off_d = off_q;
    alloc  = 1'b0;   store  = 1'b0;   push  = 1'b0;
    rdy_d  = 1'b0;   full_d = 1'b0;
    entry  = '0;
    entry.addr = addr_u;
    wr_off  = off_u;
    wr_data = rx_data;

    if (rx_valid) begin
      evt_d  = 1'b1;   drop_d = drop_now; ovf_d = ovf_u; addr_d = addr_u;
      segc_d = segc_u; segb_d = segb_u;   off_d = off_u;
      if (drop_now) begin
        full_d = first;
      end else if (ovf_u || (need_chunk && free_chunks == '0)) begin
        ovf_d  = 1'b1;
        full_d = !ovf_u;
        if (rx_last) begin
          push         = 1'b1;
          entry.fin    = 1'b1;
          entry.err    = 1'b1;
          entry.chunks = segc_u;
          entry.len    = segb_u;
          rdy_d        = 1'b1;
        end
      end else begin
        store  = 1'b1;
        alloc  = need_chunk;
        segc_d = segc_inc;
        segb_d = segb_inc;
        off_d  = off_u + OFF_W'(1);
        if (rx_last) begin
          push         = 1'b1;
          entry.fin    = 1'b1;
          entry.chunks = segc_inc;
          entry.len    = segb_inc;
          rdy_d        = 1'b1;
        end else if (seg_done) begin
          if (two_slots) begin
            push         = 1'b1;
            entry.chunks = segc_inc;
            segc_d       = '0;
            segb_d       = '0;
          end else begin
            ovf_d  = 1'b1;
            full_d = 1'b1;
          end
        end
      end
      if (rx_last) begin
        evt_d  = 1'b0; drop_d = 1'b0; ovf_d = 1'b0;
        segc_d = '0;   segb_d = '0;   off_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0; drop_q <= 1'b0; ovf_q <= 1'b0; addr_q <= '0;
      segc_q <= '0;   segb_q <= '0;   off_q <= '0;
    end else if (rx_valid) begin
      evt_q  <= evt_d;  drop_q <= drop_d; ovf_q <= ovf_d; addr_q <= addr_d;
      segc_q <= segc_d; segb_q <= segb_d; off_q <= off_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      rdy_q  <= rdy_d;
      full_q <= full_d;
    end
  end

  assign irq_ready = rdy_q;
  assign irq_full  = full_q;

endmodule

// File: rtl/ibi_chunk_ring.sv
module ibi_chunk_ring
  import ibi_ring_pkg::*;
#(
  parameter int CHUNK_CODE = 0,
  parameter int NUM_CHUNKS = 8,
  parameter int STAT_DEPTH = 8,
  parameter int SEG_CHUNKS = 2,
  parameter int DATA_AW    = $clog2(NUM_CHUNKS) + CHUNK_CODE + 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rx_valid,
  input  logic [6:0]         rx_addr,
  input  logic [7:0]         rx_data,
  input  logic               rx_last,
  input  logic               credit_valid,
  input  logic [9:0]         credit_count,
  input  logic [7:0]         stat_deq,
  output logic [7:0]         stat_enq,
  input  logic [7:0]         stat_rd_idx,
  output logic [31:0]        stat_rd_entry,
  input  logic [DATA_AW-1:0] data_rd_addr,
  output logic [7:0]         data_rd_byte,
  output logic               irq_ibi_ready,
  output logic               irq_ring_full
);

  localparam int CHUNK_BYTES = 1 << (CHUNK_CODE + 2);
  localparam int OFF_W       = CHUNK_CODE + 2;
  localparam int CHK_W       = $clog2(NUM_CHUNKS);
  localparam int CNT_W       = $clog2(NUM_CHUNKS + 1);
  localparam int IDX_W       = $clog2(STAT_DEPTH);

  logic [1:0]       rst_sync_q;
  logic             rst_int_n;
  logic             alloc_w, store_w, push_w;
  logic [OFF_W-1:0] wr_off_w;
  logic [7:0]       wr_data_w;
  ibi_stat_t        push_entry_w;
  logic [IDX_W-1:0] slots_free_w;
  logic [CNT_W-1:0] free_chunks_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  ibi_rx_ctrl #(
    .CHUNK_BYTES(CHUNK_BYTES), .OFF_W(OFF_W), .SEG_CHUNKS(SEG_CHUNKS),
    .IDX_W(IDX_W), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_int_n),
    .rx_valid(rx_valid), .rx_addr(rx_addr), .rx_data(rx_data), .rx_last(rx_last),
    .slots_free(slots_free_w), .free_chunks(free_chunks_w),
    .alloc(alloc_w), .store(store_w), .wr_off(wr_off_w), .wr_data(wr_data_w),
    .push(push_w), .entry(push_entry_w),
    .irq_ready(irq_ibi_ready), .irq_full(irq_ring_full)
  );

  ibi_chunk_pool #(
    .NUM_CHUNKS(NUM_CHUNKS), .CHUNK_BYTES(CHUNK_BYTES),
    .CHK_W(CHK_W), .OFF_W(OFF_W), .CNT_W(CNT_W)
  ) u_pool (
    .clk(clk), .rst_n(rst_int_n),
    .alloc(alloc_w), .store(store_w), .wr_off(wr_off_w), .wr_data(wr_data_w),
    .credit_valid(credit_valid), .credit_count(credit_count),
    .rd_addr(data_rd_addr), .rd_byte(data_rd_byte), .free_chunks(free_chunks_w)
  );

  ibi_stat_ring #(
    .DEPTH(STAT_DEPTH), .IDX_W(IDX_W)
  ) u_ring (
    .clk(clk), .rst_n(rst_int_n),
    .push(push_w), .push_entry(push_entry_w),
    .deq_ptr(stat_deq), .rd_idx(stat_rd_idx),
    .enq_ptr(stat_enq), .rd_entry(stat_rd_entry), .slots_free(slots_free_w)
  );

endmodule

// File: rtl/ibi_ring_chk.sv
module ibi_ring_chk #(
  parameter int STAT_DEPTH = 8,
  parameter int SEG_CHUNKS = 2,
  parameter int IDX_W      = 3,
  parameter int CNT_W      = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push,
  input logic             push_last,
  input logic [7:0]       push_chunks,
  input logic [11:0]      push_len,
  input logic [IDX_W-1:0] slots_free,
  input logic             alloc,
  input logic [CNT_W-1:0] free_chunks,
  input logic             irq_ready,
  input logic [7:0]       stat_enq
);

  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> slots_free != '0);

  // R5
  enq_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> stat_enq == (($past(stat_enq) == 8'(STAT_DEPTH - 1)) ? 8'd0 : $past(stat_enq) + 8'd1));

  // R5
  enq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !push |=> $stable(stat_enq));

  // R8
  chunk_avail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    alloc |-> free_chunks != '0);

  // R4
  seg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !push_last) |-> (push_len == 12'd0 && push_chunks == 8'(SEG_CHUNKS)));

  // R11
  ready_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && push_last) |=> irq_ready);

  // R11
  ready_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready |-> $past(push && push_last));

endmodule

bind ibi_chunk_ring ibi_ring_chk #(
  .STAT_DEPTH(STAT_DEPTH), .SEG_CHUNKS(SEG_CHUNKS), .IDX_W(IDX_W), .CNT_W(CNT_W)
) u_chk (
  .clk(clk), .rst_n(rst_int_n),
  .push(push_w), .push_last(push_entry_w.fin),
  .push_chunks(push_entry_w.chunks), .push_len(push_entry_w.len),
  .slots_free(slots_free_w), .alloc(alloc_w), .free_chunks(free_chunks_w),
  .irq_ready(irq_ibi_ready), .stat_enq(stat_enq)
);

// File: tb/test_ibi_chunk_ring.sv
module test_ibi_chunk_ring;

  localparam int CB = 4, NCH = 8, SD = 8, SEG = 2, AW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0, rx_last = 1'b0, credit_valid = 1'b0;
  logic [6:0] rx_addr = '0;
  logic [7:0] rx_data = '0, stat_deq = '0, stat_rd_idx = '0;
  logic [9:0] credit_count = '0;
  logic [AW-1:0] data_rd_addr = '0;
  logic [7:0] stat_enq, data_rd_byte;
  logic [31:0] stat_rd_entry;
  logic irq_ibi_ready, irq_ring_full;

  int n_run = 0, n_fail = 0, rdy_cnt = 0, full_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  ibi_chunk_ring i_ibi_chunk_ring (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_addr(rx_addr),
    .rx_data(rx_data), .rx_last(rx_last), .credit_valid(credit_valid),
    .credit_count(credit_count), .stat_deq(stat_deq), .stat_enq(stat_enq),
    .stat_rd_idx(stat_rd_idx), .stat_rd_entry(stat_rd_entry),
    .data_rd_addr(data_rd_addr), .data_rd_byte(data_rd_byte),
    .irq_ibi_ready(irq_ibi_ready), .irq_ring_full(irq_ring_full)
  );

  always @(negedge clk) begin
    if (rst_n && irq_ibi_ready) rdy_cnt++;
    if (rst_n && irq_ring_full) full_cnt++;
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [7:0] bval(input int ev, input int i);
    return 8'(ev * 37 + i * 5 + 1);
  endfunction

  function automatic logic [31:0] mk(input bit fin, input bit err, input logic [6:0] a,
                                     input int ch, input int len);
    return {fin, err, a, 3'b000, 8'(ch), 12'(len)};
  endfunction

  task automatic entry_at(input int idx, output logic [31:0] v);
    stat_rd_idx = 8'(idx);
    #1 v = stat_rd_entry;
  endtask

  task automatic byte_at(input int addr, output logic [7:0] v);
    data_rd_addr = AW'(addr);
    #1 v = data_rd_byte;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rx_valid = 1'b0; rx_last = 1'b0; credit_valid = 1'b0; stat_deq = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_event(input logic [6:0] a, input int len, input int ev);
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      rx_valid = 1'b1; rx_addr = a; rx_data = bval(ev, i); rx_last = (i == len - 1);
    end
    @(negedge clk);
    rx_valid = 1'b0; rx_last = 1'b0;
    @(negedge clk);
  endtask

  task automatic give_credit(input int n);
    @(negedge clk);
    credit_valid = 1'b1; credit_count = 10'(n);
    @(negedge clk);
    credit_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    logic [31:0] e;
    logic [7:0]  b;
    int m_enq, m_chunk, r0, f0;

    do_reset();
    // R12 reset state
    chk("R12 enq after reset", 32'(stat_enq), 0);
    chk("R12 ready low after reset", 32'(irq_ibi_ready), 0);
    chk("R12 full low after reset", 32'(irq_ring_full), 0);

    // sweep of payload lengths with software draining after each event
    m_enq = 0; m_chunk = 0;
    for (int len = 1; len <= 20; len++) begin
      logic [6:0] a;
      int nf, fl, fc, tot;
      a = 7'(len * 3 + 5);
      r0 = rdy_cnt; f0 = full_cnt;
      send_event(a, len, len);
      nf = (len - 1) / (SEG * CB);
      fl = len - nf * SEG * CB;
      fc = (fl + CB - 1) / CB;
      for (int k = 0; k < nf; k++) begin
        entry_at((m_enq + k) % SD, e);
        chk("R4 R2 non-final entry", e, mk(0, 0, a, SEG, 0));
      end
      entry_at((m_enq + nf) % SD, e);
      chk(nf == 0 ? "R3 R2 single entry" : "R4 R2 closing entry", e, mk(1, 0, a, fc, fl));
      m_enq = (m_enq + nf + 1) % SD;
      chk("R5 enqueue pointer", 32'(stat_enq), 32'(m_enq));
      for (int i = 0; i < len; i++) begin
        byte_at(((m_chunk + i / CB) % NCH) * CB + i % CB, b);
        chk("R1 R6 byte placement", 32'(b), 32'(bval(len, i)));
      end
      tot = nf * SEG + fc;
      m_chunk = (m_chunk + tot) % NCH;
      chk("R11 one ready pulse", 32'(rdy_cnt - r0), 1);
      chk("R8 no full pulse", 32'(full_cnt - f0), 0);
      stat_deq = 8'(m_enq);
      give_credit(tot);
    end

    // chunk exhaustion
    do_reset();
    r0 = rdy_cnt; f0 = full_cnt;
    send_event(7'h2A, 40, 100);
    for (int k = 0; k < 4; k++) begin
      entry_at(k, e);
      chk("R4 segment before exhaustion", e, mk(0, 0, 7'h2A, SEG, 0));
    end
    entry_at(4, e);
    chk("R8 error closing entry", e, mk(1, 1, 7'h2A, 0, 0));
    chk("R8 full pulse count", 32'(full_cnt - f0), 1);
    chk("R11 ready after error close", 32'(rdy_cnt - r0), 1);
    byte_at(0, b);
    chk("R8 discarded byte leaves chunk 0", 32'(b), 32'(bval(100, 0)));
    byte_at(31, b);
    chk("R1 last stored byte", 32'(b), 32'(bval(100, 31)));
    send_event(7'h0C, 1, 150);
    entry_at(5, e);
    chk("R7 no chunks without credit", e, mk(1, 1, 7'h0C, 0, 0));
    give_credit(8);
    send_event(7'h11, 3, 101);
    entry_at(6, e);
    chk("R7 credits make chunks usable", e, mk(1, 0, 7'h11, 1, 3));
    byte_at(0, b);
    chk("R6 allocation wrapped to chunk 0", 32'(b), 32'(bval(101, 0)));
    byte_at(2, b);
    chk("R6 wrapped chunk offset 2", 32'(b), 32'(bval(101, 2)));
    chk("R5 enqueue after exhaustion", 32'(stat_enq), 7);

    // status slot exhaustion
    do_reset();
    for (int j = 0; j < 6; j++) send_event(7'h05, 1, 200 + j);
    r0 = rdy_cnt; f0 = full_cnt;
    send_event(7'h33, 12, 210);
    entry_at(6, e);
    chk("R9 error entry when slots short", e, mk(1, 1, 7'h33, 2, 8));
    chk("R9 full pulse count", 32'(full_cnt - f0), 1);
    chk("R9 enqueue pointer", 32'(stat_enq), 7);
    byte_at(6 * CB, b);
    chk("R9 stored byte 0", 32'(b), 32'(bval(210, 0)));
    byte_at(7 * CB + 3, b);
    chk("R9 stored byte 7", 32'(b), 32'(bval(210, 7)));
    r0 = rdy_cnt; f0 = full_cnt;
    send_event(7'h44, 2, 230);
    chk("R10 enqueue unchanged", 32'(stat_enq), 7);
    chk("R10 full pulse", 32'(full_cnt - f0), 1);
    chk("R10 no ready pulse", 32'(rdy_cnt - r0), 0);
    stat_deq = 8'd7;
    give_credit(8);
    send_event(7'h55, 5, 220);
    entry_at(7, e);
    chk("R3 entry in last slot", e, mk(1, 0, 7'h55, 2, 5));
    chk("R5 enqueue wraps to 0", 32'(stat_enq), 0);
    byte_at(0, b);
    chk("R6 chunk 0 after wrap", 32'(b), 32'(bval(220, 0)));
    byte_at(CB, b);
    chk("R1 second chunk first byte", 32'(b), 32'(bval(220, 4)));

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog R11: actual not finished expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule